// File: doc/BRIEF.md
# Bounded-Latency Handshake Monitor

This block sits beside a request/acknowledge pair that shares one clock and judges every new request. A request begins when `req` goes from low to high between two samples. From then on the monitor counts clock edges and waits for `ack` to go from low to high. If that rise comes inside a window of `WIN_MIN` to `WIN_MAX` edges, the request passes. If it comes too early, or if the window runs out with no rise, the request fails. Each verdict produces a one-cycle pulse and steps a saturating counter.

Only one request is judged at a time. A further rise of `req` while a check is still open takes no part in any verdict and is only tallied. Edges are found by comparing each input with the copy sampled at the previous clock edge. Those copies are forced high by reset, so a level that is already high when reset is released does not count as a rise. Pulling `enable` low drops any open check without a verdict and stops new checks from starting. The edge history keeps tracking the inputs while `enable` is low. The block carries no data stream, so every pin is a plain control or status signal with no back-pressure.

Top module: `hs_latency_mon`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pass_pulse` and `fail_pulse` are 0 and all three counters are 0. Reset sets the sampled copies of `req` and `ack` to 1, so a level held high across the release of reset is not seen as a rise.
- R2: A check opens only at a clock edge where `req` is 1, the sampled copy of `req` from the previous edge is 0, `enable` is 1 and no check is open. The edge where the check opens is delay 0.
- R3: If the first rise of `ack` after a check opens is seen at delay d, with `WIN_MIN` <= d <= `WIN_MAX`, then `pass_pulse` is 1 for the one cycle after that edge. At that same edge `pass_count` steps by one and the check closes.
- R4: If the first rise of `ack` is seen at delay d with 1 <= d < `WIN_MIN`, then `fail_pulse` is 1 for the one cycle after that edge. At that same edge `fail_count` steps by one and the check closes.
- R5: If no rise of `ack` is seen by delay `WIN_MAX`, then `fail_pulse` is 1 for the one cycle after the edge at delay `WIN_MAX`, `fail_count` steps by one and the check closes.
- R6: An `ack` that is already high when the check opens and stays high does not count as a rise, so that check ends as in R5.
- R7: A `req` held high after a check closes opens no further check and produces no further pulse.
- R8: A rise of `req` seen while a check is open is ignored for every verdict. It steps `overlap_count` by one at that edge.
- R9: At an edge where `enable` is 0, any open check is dropped with no pulse, no check opens and no counter changes. A `req` rise at such an edge is not remembered once `enable` returns to 1.
- R10: Each counter is `CNT_W` bits wide (default 16). When a counter holds all ones it stays there on further events.
- R11: `pass_pulse` and `fail_pulse` are never 1 in the same cycle, and neither is 1 for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock; all sampling is on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | When high, checks may open and be judged |
| req | input | 1 | Request line being watched |
| ack | input | 1 | Acknowledge line being watched |
| pass_pulse | output | 1 | One-cycle pulse on an in-window acknowledge |
| fail_pulse | output | 1 | One-cycle pulse on an early acknowledge or a timeout |
| pass_count | output | CNT_W | Saturating count of passed checks |
| fail_count | output | CNT_W | Saturating count of failed checks |
| overlap_count | output | CNT_W | Saturating count of request rises ignored during an open check |

## Verification
The bench builds the monitor with `WIN_MIN` = 2, `WIN_MAX` = 4 and `CNT_W` = 4. The lower bound of 2 leaves room for an acknowledge at delay 1, which is too early and must fail. This case cannot arise with the default lower bound of 1. The narrow counters reach saturation after fifteen passes, so the hold at all ones is exercised within a short run. Directed cases sweep the acknowledge delay across both window edges and one step past each. They also cover an acknowledge that is already high, a held request, a request rise during an open check, dropping `enable` in mid-check, and a reset in mid-check with `req` held high through its release.

// File: rtl/hlm_pkg.sv
package hlm_pkg;

  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_PASS = 2'd1,
    VERDICT_FAIL = 2'd2
  } verdict_e;

  // Indices of the event counters kept by the top module
  localparam int unsigned EV_PASS    = 0;
  localparam int unsigned EV_FAIL    = 1;
  localparam int unsigned EV_OVERLAP = 2;
  localparam int unsigned EV_COUNT   = 3;

endpackage

// File: rtl/hlm_edge.sv
// Rising-edge finder for a bundle of lines; history resets high so that a
// level already present at reset release is not taken as a new edge.
module hlm_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sig,
  output logic [WIDTH-1:0] rise
);

  logic [WIDTH-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '1;
    else        hist_q <= sig;
  end

  assign rise = sig & ~hist_q;

endmodule

// File: rtl/hlm_window.sv
// Tracks one open check and judges it against the latency window.
module hlm_window
  import hlm_pkg::*;
#(
  parameter int unsigned WIN_MIN = 1,
  parameter int unsigned WIN_MAX = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     req_rise,
  input  logic     ack_rise,
  output verdict_e verdict,
  output logic     overlap
);

  localparam int unsigned AGE_W = (WIN_MAX < 1) ? 1 : $clog2(WIN_MAX + 1);
  localparam logic [AGE_W-1:0] AGE_MIN = AGE_W'(WIN_MIN);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WIN_MAX);

  logic             open_q;
  logic [AGE_W-1:0] age_q;  // delay that the coming edge represents

  always_comb begin
    verdict = VERDICT_NONE;
    if (enable && open_q) begin
      if (ack_rise)            verdict = (age_q >= AGE_MIN) ? VERDICT_PASS : VERDICT_FAIL;
      else if (age_q == AGE_MAX) verdict = VERDICT_FAIL;
    end
  end

  assign overlap = enable && open_q && req_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      age_q  <= '0;
    end else if (!enable) begin
      open_q <= 1'b0;
      age_q  <= '0;
    end else if (open_q) begin
      if (verdict != VERDICT_NONE) begin
        open_q <= 1'b0;
        age_q  <= '0;
      end else begin
        age_q <= age_q + 1'b1;
      end
    end else if (req_rise) begin
      open_q <= 1'b1;
      age_q  <= AGE_W'(1);
    end
  end

endmodule

// File: rtl/hlm_sat_cnt.sv
module hlm_sat_cnt #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [WIDTH-1:0] value
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     value <= '0;
    else if (bump && value != '1)   value <= value + 1'b1;
  end

endmodule

// File: rtl/hs_latency_mon.sv
module hs_latency_mon
  import hlm_pkg::*;
#(
  parameter int unsigned WIN_MIN = 1,
  parameter int unsigned WIN_MAX = 3,
  parameter int unsigned CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             req,
  input  logic             ack,
  output logic             pass_pulse,
  output logic             fail_pulse,
  output logic [CNT_W-1:0] pass_count,
  output logic [CNT_W-1:0] fail_count,
  output logic [CNT_W-1:0] overlap_count
);

  logic [1:0]          rises;
  verdict_e            verdict;
  logic                overlap;
  logic [EV_COUNT-1:0] events;
  logic [CNT_W-1:0]    counts [EV_COUNT];

  hlm_edge #(.WIDTH(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  ({ack, req}),
    .rise (rises)
  );

  hlm_window #(.WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .req_rise(rises[0]),
    .ack_rise(rises[1]),
    .verdict (verdict),
    .overlap (overlap)
  );

  assign events[EV_PASS]    = (verdict == VERDICT_PASS);
  assign events[EV_FAIL]    = (verdict == VERDICT_FAIL);
  assign events[EV_OVERLAP] = overlap;

  for (genvar gi = 0; gi < EV_COUNT; gi++) begin : g_cnt
    hlm_sat_cnt #(.WIDTH(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .bump (events[gi]),
      .value(counts[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_pulse <= 1'b0;
      fail_pulse <= 1'b0;
    end else begin
      pass_pulse <= events[EV_PASS];
      fail_pulse <= events[EV_FAIL];
    end
  end

  assign pass_count    = counts[EV_PASS];
  assign fail_count    = counts[EV_FAIL];
  assign overlap_count = counts[EV_OVERLAP];

endmodule

// File: rtl/hlm_checker.sv
module hlm_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             pass_pulse,
  input logic             fail_pulse,
  input logic [CNT_W-1:0] pass_count,
  input logic [CNT_W-1:0] fail_count
);

  p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_pulse && fail_pulse));

  p_pass_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |=> !pass_pulse);

  p_fail_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |=> !fail_pulse);

  p_enable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!pass_pulse && !fail_pulse));

  p_pass_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |-> (pass_count == (($past(pass_count) == '1) ? $past(pass_count)
                                                             : $past(pass_count) + 1'b1)));

  p_fail_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_pulse |-> $stable(fail_count));

  p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_count == '1) |=> (pass_count == '1));

endmodule

bind hs_latency_mon hlm_checker #(.CNT_W(CNT_W)) u_hlm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .pass_pulse(pass_pulse),
  .fail_pulse(fail_pulse),
  .pass_count(pass_count),
  .fail_count(fail_count)
);

// File: tb/test_hs_latency_mon.sv
module test_hs_latency_mon;

  localparam int CLK_PERIOD = 10;
  localparam int WMIN = 2;
  localparam int WMAX = 4;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic req = 1'b0;
  logic ack = 1'b0;
  logic pass_pulse, fail_pulse;
  logic [CW-1:0] pass_count, fail_count, overlap_count;

  int n_chk = 0;
  int n_bad = 0;
  int e_pass = 0;
  int e_fail = 0;
  int e_ovl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_latency_mon #(.WIN_MIN(WMIN), .WIN_MAX(WMAX), .CNT_W(CW)) i_hs_latency_mon (
    .clk(clk), .rst_n(rst_n), .enable(enable), .req(req), .ack(ack),
    .pass_pulse(pass_pulse), .fail_pulse(fail_pulse),
    .pass_count(pass_count), .fail_count(fail_count), .overlap_count(overlap_count)
  );

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_counts(string tag);
    chk({tag, " pass_count"}, int'(pass_count), sat(e_pass));
    chk({tag, " fail_count"}, int'(fail_count), sat(e_fail));
    chk({tag, " overlap_count"}, int'(overlap_count), sat(e_ovl));
  endtask

  // One request; ack rises at delay d (0 = never), or is high throughout.
  // kind: 1 = pass, 2 = fail
  task automatic run_hs(string tag, int d, bit ack_pre, int exp_kind, int exp_at);
    int kind = 0;
    int at = -1;
    int npulse = 0;
    @(negedge clk); req = 1'b1; ack = ack_pre;
    for (int i = 1; i <= WMAX + 2; i++) begin
      @(negedge clk);
      if (pass_pulse || fail_pulse) begin
        npulse++;
        kind = pass_pulse ? 1 : 2;
        at = i - 1;
      end
      if (!ack_pre) ack = (i == d);
    end
    req = 1'b0; ack = 1'b0;
    chk({tag, " verdict"}, kind, exp_kind);
    chk({tag, " delay"}, at, exp_at);
    chk({tag, " pulses"}, npulse, 1);
    if (exp_kind == 1) e_pass++; else e_fail++;
    chk_counts(tag);
  endtask

  task automatic t_reset_state();
    chk("R1 pass_pulse in reset", int'(pass_pulse), 0);
    chk("R1 fail_pulse in reset", int'(fail_pulse), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pulses after release", int'(pass_pulse | fail_pulse), 0);
    chk_counts("R1");
  endtask

  task automatic t_window_sweep();
    run_hs("R3 ack at min", WMIN, 1'b0, 1, WMIN);
    run_hs("R3 ack inside", WMIN + 1, 1'b0, 1, WMIN + 1);
    run_hs("R3 ack at max", WMAX, 1'b0, 1, WMAX);
    run_hs("R4 ack early", 1, 1'b0, 2, 1);
    run_hs("R5 ack late", WMAX + 1, 1'b0, 2, WMAX);
    run_hs("R5 no ack", 0, 1'b0, 2, WMAX);
    run_hs("R6 ack level high", 0, 1'b1, 2, WMAX);
  endtask

  task automatic t_held_req();
    int np = 0;
    int nf = 0;
    @(negedge clk); req = 1'b1; ack = 1'b0;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      np += int'(pass_pulse);
      nf += int'(fail_pulse);
      ack = (i == 3);
    end
    req = 1'b0; ack = 1'b0;
    e_pass++;
    chk("R7 held req passes", np, 1);
    chk("R7 held req no fail", nf, 0);
    chk_counts("R7 R2");
  endtask

  task automatic t_overlap();
    int at = -1;
    int np = 0;
    @(negedge clk); req = 1'b1; ack = 1'b0;
    for (int i = 1; i <= WMAX + 2; i++) begin
      @(negedge clk);
      if (pass_pulse) begin np++; at = i - 1; end
      chk("R8 no fail during overlap", int'(fail_pulse), 0);
      req = (i != 1);
      ack = (i == 3);
    end
    req = 1'b0; ack = 1'b0;
    e_pass++; e_ovl++;
    chk("R8 original check delay", at, 3);
    chk("R8 single pass", np, 1);
    chk_counts("R8");
  endtask

  task automatic t_enable();
    int n = 0;
    @(negedge clk); req = 1'b1; ack = 1'b0;
    for (int i = 1; i <= WMAX + 3; i++) begin
      @(negedge clk);
      n += int'(pass_pulse | fail_pulse);
      if (i == 1) enable = 1'b0;
      ack = (i == 3);
    end
    chk("R9 dropped check silent", n, 0);
    chk_counts("R9 drop");
    @(negedge clk); req = 1'b0;
    @(negedge clk); req = 1'b1;
    @(negedge clk); enable = 1'b1;
    n = 0;
    for (int i = 1; i <= WMAX + 2; i++) begin
      @(negedge clk);
      n += int'(pass_pulse | fail_pulse);
    end
    req = 1'b0;
    chk("R9 rise while disabled forgotten", n, 0);
    chk_counts("R9 forget");
  endtask

  task automatic t_reset_mid();
    int n = 0;
    @(negedge clk); req = 1'b1; ack = 1'b0;
    @(negedge clk);
    @(negedge clk); rst_n = 1'b0;
    e_pass = 0; e_fail = 0; e_ovl = 0;
    @(negedge clk);
    chk_counts("R1 cleared");
    rst_n = 1'b1;
    for (int i = 1; i <= WMAX + 2; i++) begin
      @(negedge clk);
      n += int'(pass_pulse | fail_pulse);
    end
    req = 1'b0;
    chk("R1 held req across release", n, 0);
    chk_counts("R1 after release");
  endtask

  task automatic t_saturate();
    for (int k = 0; k < CMAX + 1; k++) run_hs("R10 saturate", WMIN, 1'b0, 1, WMIN);
    chk("R10 pass_count held at max", int'(pass_count), CMAX);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog R1-all actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_window_sweep();
    t_held_req();
    t_overlap();
    t_enable();
    t_reset_mid();
    t_saturate();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule